// File: doc/BRIEF.md
# Interrupt Cause, Mask and Throttle Controller

This block collects interrupt causes from hardware event sources and from software, gates them with a per-cause enable mask, and drives one level-sensitive interrupt line toward the host. Software reaches it through a plain 32-bit register port: one register holds the pending causes, two write-only strobes set and clear bits in the mask, one strobe raises causes directly, one register chooses which mask bits are dropped automatically on acknowledge, one register holds the throttle interval, and one control register enables the automatic masking.

Acknowledging happens either by reading the cause register or by writing ones to it. A read clears the causes only when the line is up or the mask is empty. With automatic masking enabled, an acknowledge also removes the selected bits from the mask. A throttle interval, counted in units of about 256 ns by a cycle prescaler, postpones the rising edge of the line so the host is not interrupted more often than the interval allows. Urgent posts skip the postponement.

Top module: `irq_throttle_ctrl`

## Requirements
- R1: After reset the cause register, mask, auto-mask selection, throttle interval and control register all read as zero, and `irq_out` is low.
- R2: A read at offset 0 returns, one cycle after the read strobe, the interrupt line state in bit 31 and the pending causes in bits 30:0.
- R3: A read at offset 0 clears bits 30:0 of the cause register when the line was high or the mask was all zero at the time of the read; otherwise the causes are kept.
- R4: When bit 0 of the control register (offset 6) is set and the line was high, a read at offset 0 also clears every mask bit that is set in the auto-mask register (offset 4).
- R5: A write at offset 0 clears each cause bit written as one; with control bit 0 set it also clears the mask bits selected by the auto-mask register, whatever the line state.
- R6: A write at offset 1 ORs the data into the mask and a write at offset 2 removes the written bits from it; reads at offset 1 or 2 return the mask.
- R7: A write at offset 3, or a `post_valid` pulse, sets the given cause bits; a cause posted in the same cycle as an acknowledge survives it, and posting an already pending cause changes nothing, including a running throttle timer.
- R8: With a throttle interval of zero, `irq_out` rises at the same clock edge at which a cause becomes pending under the mask.
- R9: With a nonzero interval N (offset 5, low 16 bits, read back truncated), `irq_out` rises N×TICK_CYCLES clock edges after the edge at which a masked cause first became pending; further posts while the timer runs do not restart it.
- R10: A `post_valid` pulse with `post_urgent` set that leaves a masked cause pending raises `irq_out` at that edge regardless of the interval.
- R11: When no cause is pending under the mask, `irq_out` is low at the next edge and the throttle timer is cancelled, so a later pending cause waits a full fresh interval; `irq_out` is never high without a pending masked cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset (0 cause, 1 mask set, 2 mask clear, 3 cause set, 4 auto-mask, 5 throttle, 6 control) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after `reg_rd` |
| post_valid | input | 1 | Hardware cause post strobe |
| post_cause | input | 31 | Cause bits to post |
| post_urgent | input | 1 | Post bypasses the throttle interval |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
The hardest state to reach is a throttle timer that is already running when something else happens to the pending set: a second post arriving halfway through the interval, or the mask being cleared and set again before the timer expires. The bench drives these from the ports by counting clock edges from the posting edge and injecting the second event at a fixed edge count, then measures the edge on which the line rises against N×TICK_CYCLES computed from the interval. The interval is swept over a range of values with a small prescaler so every delay is compared arithmetically.

// File: rtl/irq_throttle_pkg.sv
package irq_throttle_pkg;
  localparam int DATA_W  = 32;
  localparam int CAUSE_W = DATA_W - 1;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_CAUSE = 3'd0,
    OFS_MSET  = 3'd1,
    OFS_MCLR  = 3'd2,
    OFS_CSET  = 3'd3,
    OFS_AMASK = 3'd4,
    OFS_THROT = 3'd5,
    OFS_CTRL  = 3'd6
  } reg_ofs_e;
endpackage

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
  import irq_throttle_pkg::*;
#(
  parameter int ITR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               post_valid,
  input  logic [CAUSE_W-1:0] post_cause,
  input  logic               irq_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [CAUSE_W-1:0] mask_q,
  output logic [CAUSE_W-1:0] cause_n,
  output logic [CAUSE_W-1:0] mask_n,
  output logic [ITR_W-1:0]   itr_q,
  output logic [DATA_W-1:0]  rdata_q
);
  logic [CAUSE_W-1:0] amask_q, amask_n;
  logic [ITR_W-1:0]   itr_n;
  logic               ame_q, ame_n;
  logic               rd_cause;
  logic [DATA_W-1:0]  rdata_mux;

  assign rd_cause = reg_rd && (reg_addr == OFS_CAUSE);

  // Next-state: acknowledge by read first, then write, then hardware post.
  always_comb begin
    cause_n = cause_q;
    mask_n  = mask_q;
    amask_n = amask_q;
    itr_n   = itr_q;
    ame_n   = ame_q;
    if (rd_cause) begin
      if (irq_q || (mask_q == '0)) cause_n = '0;
      if (ame_q && irq_q) mask_n = mask_n & ~amask_q;
    end
    if (reg_wr) begin
      unique case (reg_addr)
        OFS_CAUSE: begin
          cause_n = cause_n & ~reg_wdata[CAUSE_W-1:0];
          if (ame_q) mask_n = mask_n & ~amask_q;
        end
        OFS_MSET:  mask_n  = mask_n | reg_wdata[CAUSE_W-1:0];
        OFS_MCLR:  mask_n  = mask_n & ~reg_wdata[CAUSE_W-1:0];
        OFS_CSET:  cause_n = cause_n | reg_wdata[CAUSE_W-1:0];
        OFS_AMASK: amask_n = reg_wdata[CAUSE_W-1:0];
        OFS_THROT: itr_n   = reg_wdata[ITR_W-1:0];
        OFS_CTRL:  ame_n   = reg_wdata[0];
        default: ;
      endcase
    end
    if (post_valid) cause_n = cause_n | post_cause;
  end

  always_comb begin
    rdata_mux = '0;
    unique case (reg_addr)
      OFS_CAUSE: rdata_mux = {irq_q, cause_q};
      OFS_MSET,
      OFS_MCLR:  rdata_mux = {1'b0, mask_q};
      OFS_AMASK: rdata_mux = {1'b0, amask_q};
      OFS_THROT: rdata_mux = DATA_W'(itr_q);
      OFS_CTRL:  rdata_mux = DATA_W'(ame_q);
      default:   rdata_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
      amask_q <= '0;
      itr_q   <= '0;
      ame_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      cause_q <= cause_n;
      mask_q  <= mask_n;
      amask_q <= amask_n;
      itr_q   <= itr_n;
      ame_q   <= ame_n;
      if (reg_rd) rdata_q <= rdata_mux;
    end
  end
endmodule

// File: rtl/irq_throttle_timer.sv
module irq_throttle_timer #(
  parameter int ITR_W       = 16,
  parameter int TICK_CYCLES = 52
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cancel,
  input  logic [ITR_W-1:0] units,
  output logic             running,
  output logic             fire
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;
  logic [ITR_W-1:0] units_q;
  logic             run_q;

  assign running = run_q;
  assign fire    = run_q && (units_q == ITR_W'(1)) && (pre_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      pre_q   <= '0;
      units_q <= '0;
    end else if (cancel || fire) begin
      run_q <= 1'b0;
    end else if (start) begin
      run_q   <= 1'b1;
      pre_q   <= PRE_TOP;
      units_q <= units;
    end else if (run_q) begin
      if (pre_q == '0) begin
        pre_q   <= PRE_TOP;
        units_q <= units_q - ITR_W'(1);
      end else begin
        pre_q <= pre_q - PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/irq_throttle_ctrl.sv
module irq_throttle_ctrl
  import irq_throttle_pkg::*;
#(
  parameter int ITR_W       = 16,
  parameter int TICK_CYCLES = 52
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               post_valid,
  input  logic [CAUSE_W-1:0] post_cause,
  input  logic               post_urgent,
  output logic               irq_out
);
  logic [CAUSE_W-1:0] cause_q, mask_q, cause_n, mask_n;
  logic [ITR_W-1:0]   itr_q;
  logic               irq_q, irq_n;
  logic               pend_n, immediate;
  logic               tmr_start, tmr_cancel, tmr_run, tmr_fire;

  irq_cause_regs #(.ITR_W(ITR_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .post_valid(post_valid), .post_cause(post_cause),
    .irq_q(irq_q),
    .cause_q(cause_q), .mask_q(mask_q), .cause_n(cause_n), .mask_n(mask_n),
    .itr_q(itr_q), .rdata_q(reg_rdata)
  );

  irq_throttle_timer #(.ITR_W(ITR_W), .TICK_CYCLES(TICK_CYCLES)) u_tmr (
    .clk(clk), .rst(rst),
    .start(tmr_start), .cancel(tmr_cancel), .units(itr_q),
    .running(tmr_run), .fire(tmr_fire)
  );

  // Line decision on the post-update pending set.
  assign pend_n     = |(cause_n & mask_n);
  assign immediate  = (itr_q == '0) || (post_valid && post_urgent) || tmr_fire;
  assign irq_n      = pend_n && (irq_q || immediate);
  assign tmr_cancel = !pend_n || irq_q || immediate;
  assign tmr_start  = pend_n && !irq_q && !immediate && !tmr_run;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_n;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/irq_throttle_ctrl_chk.sv
module irq_throttle_ctrl_chk
  import irq_throttle_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               post_valid,
  input logic [CAUSE_W-1:0] post_cause,
  input logic               irq_out,
  input logic [CAUSE_W-1:0] cause_q,
  input logic [CAUSE_W-1:0] mask_q
);
  a_r2_read_image: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_CAUSE) |=>
      (reg_rdata == {$past(irq_out), $past(cause_q)}));

  a_r6_mask_set: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFS_MSET) |=>
      ((mask_q & $past(reg_wdata[CAUSE_W-1:0])) == $past(reg_wdata[CAUSE_W-1:0])));

  a_r6_mask_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFS_MCLR) |=>
      ((mask_q & $past(reg_wdata[CAUSE_W-1:0])) == '0));

  a_r7_post_kept: assert property (@(posedge clk) disable iff (rst)
    post_valid |=> ((cause_q & $past(post_cause)) == $past(post_cause)));

  a_r11_line_needs_pending: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (|(cause_q & mask_q)));
endmodule

bind irq_throttle_ctrl irq_throttle_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .post_valid(post_valid),
  .post_cause(post_cause), .irq_out(irq_out), .cause_q(cause_q), .mask_q(mask_q)
);

// File: tb/irq_throttle_ctrl_tb.sv
`timescale 1ns/100ps
module irq_throttle_ctrl_tb;
  localparam int T = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        post_valid = 1'b0, post_urgent = 1'b0;
  logic [30:0] post_cause = '0;
  logic        irq_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_throttle_ctrl #(.ITR_W(16), .TICK_CYCLES(T)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .post_valid(post_valid),
    .post_cause(post_cause), .post_urgent(post_urgent), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic post(input logic [30:0] c, input logic urg);
    @(negedge clk); post_valid = 1'b1; post_cause = c; post_urgent = urg;
    @(negedge clk); post_valid = 1'b0; post_urgent = 1'b0;
  endtask

  // Drive one event (post or write), count edges until irq_out is high.
  // mid_k > 0: post mid_c again at that edge count.
  task automatic measure(input bit use_post, input logic [2:0] a, input logic [31:0] d,
                         input logic urg, input int mid_k, input logic [30:0] mid_c,
                         output int k);
    @(negedge clk);
    if (use_post) begin post_valid = 1'b1; post_cause = d[30:0]; post_urgent = urg; end
    else begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
    k = 0;
    do begin
      @(posedge clk); #1; k++;
      post_valid = 1'b0; post_urgent = 1'b0; reg_wr = 1'b0;
      if (mid_k > 0 && k == mid_k) begin post_valid = 1'b1; post_cause = mid_c; end
    end while (!irq_out && k < 500);
  endtask

  task automatic cleanup();
    logic [31:0] d;
    wr(3'd6, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd0, d);
    wr(3'd5, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    for (int a = 0; a < 7; a++) begin
      if (a == 3) continue;
      rd(3'(a), d); chk("R1 reg", d, 32'h0);
    end

    // R6: mask set/clear sweep
    for (int i = 0; i < 31; i += 5) begin
      logic [30:0] m = 31'h1 << i;
      logic [30:0] m2 = m | 31'h4000_0001;
      wr(3'd1, {1'b0, m2}); rd(3'd1, d); chk("R6 set", d, {1'b0, m2});
      wr(3'd2, {1'b0, m});  rd(3'd2, d); chk("R6 clear", d, {1'b0, m2 & ~m});
      wr(3'd2, 32'hFFFF_FFFF);
    end

    // R7/R2/R3: software set, mask zero read clears
    wr(3'd3, 32'h0000_00A5);
    rd(3'd0, d); chk("R2 R7 cause image", d, 32'h0000_00A5);
    rd(3'd0, d); chk("R3 cleared with empty mask", d, 32'h0);

    // R3: mask nonzero and line low keeps causes
    wr(3'd1, 32'h2);
    post(31'h1, 1'b0);
    chk("R3 line low", {31'b0, irq_out}, 32'h0);
    rd(3'd0, d); chk("R3 kept 1st", d, 32'h1);
    rd(3'd0, d); chk("R3 kept 2nd", d, 32'h1);
    cleanup();

    // R8/R9: interval sweep
    for (int n = 0; n <= 6; n++) begin
      wr(3'd5, 32'(n));
      wr(3'd1, 32'h1);
      measure(1'b1, 3'd0, 32'h1, 1'b0, 0, 31'h0, k);
      chk(n == 0 ? "R8 zero interval" : "R9 interval delay", 32'(k), 32'(1 + n * T));
      rd(3'd0, d); chk("R2 R3 acknowledge", d, 32'h8000_0001);
      chk("R11 drop after ack", {31'b0, irq_out}, 32'h0);
      cleanup();
    end

    // R9: a second post mid-interval does not restart the timer
    wr(3'd5, 32'd4); wr(3'd1, 32'h3);
    measure(1'b1, 3'd0, 32'h1, 1'b0, 6, 31'h2, k);
    chk("R9 no restart new cause", 32'(k), 32'(1 + 4 * T));
    cleanup();
    wr(3'd5, 32'd4); wr(3'd1, 32'h1);
    measure(1'b1, 3'd0, 32'h1, 1'b0, 5, 31'h1, k);
    chk("R7 R9 pending repost", 32'(k), 32'(1 + 4 * T));
    cleanup();

    // R10: urgent bypass
    wr(3'd5, 32'd5); wr(3'd1, 32'h4);
    measure(1'b1, 3'd0, 32'h4, 1'b1, 0, 31'h0, k);
    chk("R10 urgent", 32'(k), 32'd1);
    cleanup();

    // R11: clear mask mid-interval cancels, re-enable waits fresh interval
    wr(3'd5, 32'd4); wr(3'd1, 32'h1);
    post(31'h1, 1'b0);
    repeat (4) @(negedge clk);
    wr(3'd2, 32'h1);
    chk("R11 low after unmask", {31'b0, irq_out}, 32'h0);
    measure(1'b0, 3'd1, 32'h1, 1'b0, 0, 31'h0, k);
    chk("R11 fresh interval", 32'(k), 32'(1 + 4 * T));
    wr(3'd2, 32'h1);
    @(negedge clk);
    chk("R11 drop on clear", {31'b0, irq_out}, 32'h0);
    rd(3'd0, d); chk("R11 cause kept, line low", d, 32'h1);
    cleanup();

    // R4: auto-mask on read acknowledge
    wr(3'd6, 32'h1); wr(3'd4, 32'h5); wr(3'd1, 32'h7);
    post(31'h1, 1'b0);
    chk("R4 line up", {31'b0, irq_out}, 32'h1);
    rd(3'd0, d); chk("R4 image", d, 32'h8000_0001);
    rd(3'd1, d); chk("R4 mask after read", d, 32'h2);
    chk("R4 line down", {31'b0, irq_out}, 32'h0);
    cleanup();

    // R5: write acknowledge with and without auto-mask
    wr(3'd6, 32'h1); wr(3'd4, 32'h1); wr(3'd1, 32'h7);
    post(31'h3, 1'b0);
    wr(3'd0, 32'h1);
    rd(3'd1, d); chk("R5 mask after write ack", d, 32'h6);
    rd(3'd0, d); chk("R5 cause after write ack", d, 32'h8000_0002);
    cleanup();
    wr(3'd1, 32'h7); wr(3'd4, 32'h7);
    post(31'h6, 1'b0);
    wr(3'd0, 32'h2);
    rd(3'd1, d); chk("R5 mask kept without enable", d, 32'h7);
    rd(3'd0, d); chk("R5 cause without enable", d, 32'h8000_0004);
    cleanup();

    // R7: post survives same-cycle read acknowledge
    wr(3'd1, 32'h1);
    post(31'h1, 1'b0);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd0; post_valid = 1'b1; post_cause = 31'h8;
    @(negedge clk); reg_rd = 1'b0; post_valid = 1'b0;
    chk("R7 same-cycle image", reg_rdata, 32'h8000_0001);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R7 post survives ack", d, 32'h8);
    cleanup();

    // R9: interval register width
    wr(3'd5, 32'h0001_2345);
    rd(3'd5, d); chk("R9 interval readback", d, 32'h0000_2345);
    cleanup();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule